// File: doc/BRIEF.md
# Bus Handover Controller

This block lets an external bus master take the processor's buses between machine cycles. It watches an active-low request line. It acts on that line only at the clock edge that closes a machine cycle. The cycle sequencer marks that edge with a last-state strobe. When a request is seen there, the controller first freezes the sequencer for one clock. On the following clock it floats the address bus, the data bus and the tri-state control strobes, and it asserts an active-low acknowledge at the same time.

While the bus is handed over, the controller samples the request on every clock. The handover lasts for as long as the request stays low, with no upper limit. Both interrupt kinds are masked for the whole handover. When the request is seen high, the controller does three things at once on that clock edge: it withdraws the acknowledge, it lets the drivers take the bus back, and it releases the stall so the next machine cycle can begin.

Top module: `brq_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the block in the running state: `stall`=0, `busak_n`=1, `bus_float`=0 and `irq_mask`=0 from the clock after reset is seen.
- R2: While running, a low `busrq_n` at an edge where `last_t`=0 has no effect: `stall` stays 0 and the bus is not floated.
- R3: While running, a low `busrq_n` at an edge where `last_t`=1 makes `stall`=1 right after that edge, with `busak_n`=1 and `bus_float`=0. After the next edge, `bus_float`=1 and `busak_n`=0.
- R4: `busak_n` is 0 in exactly the cycles in which `bus_float` is 1.
- R5: Once granted, the grant holds for every edge at which `busrq_n` is sampled low, for any number of clocks, whatever `last_t` does.
- R6: While granted, an edge that samples `busrq_n`=1 returns the block to running: after that edge `busak_n`=1, `bus_float`=0 and `stall`=0.
- R7: `irq_mask` is 1 exactly while the bus is granted, so neither interrupt kind is accepted during a handover.
- R8: Once a request has been accepted, the grant follows on the next edge even if `busrq_n` has gone high in the meantime. The grant is then released at the edge after that.
- R9: If `last_t` arrives at most every MAX_TSTATES clocks while the sequencer is not stalled, then a request held low is granted within MAX_TSTATES+2 clocks.
- R10: `stall` is 1 from the accepting edge until the release edge, covering both the one-clock wait state and the whole grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busrq_n | input | 1 | Bus request from the external master, active low |
| last_t | input | 1 | Marks the final clock of the current machine cycle |
| stall | output | 1 | Keeps the sequencer from starting a new machine cycle |
| busak_n | output | 1 | Bus acknowledge, active low |
| bus_float | output | 1 | High: address, data and control drivers are in high impedance |
| irq_mask | output | 1 | High: maskable and non-maskable interrupts are held off |

## Verification
The latency property assumes that the sequencer raises `last_t` at least once every MAX_TSTATES clocks while it is not stalled, and never raises it while `stall` is high. The random phase drives `last_t` from a bench sequencer model. That model picks machine-cycle lengths between 3 and MAX_TSTATES clocks and freezes its count while `stall` is high, so the stimulus stays inside that assumption. Request toggling is unconstrained. This includes withdrawals during the wait state and during the grant.

// File: rtl/brq_pkg.sv
package brq_pkg;

    typedef enum logic [1:0] {
        BH_RUN   = 2'd0,
        BH_ARM   = 2'd1,
        BH_GRANT = 2'd2
    } bh_state_e;

    typedef struct packed {
        logic ack;
        logic float_en;
        logic stall;
        logic mask;
    } bh_out_s;

    function automatic bh_state_e bh_next(bh_state_e cur, logic req, logic last);
        bh_state_e nx;
        case (cur)
            BH_RUN:   nx = (req && last) ? BH_ARM : BH_RUN;
            BH_ARM:   nx = BH_GRANT;
            BH_GRANT: nx = req ? BH_GRANT : BH_RUN;
            default:  nx = BH_RUN;
        endcase
        return nx;
    endfunction

    function automatic bh_out_s bh_decode(bh_state_e s);
        bh_out_s o;
        o.ack      = (s == BH_GRANT);
        o.float_en = (s == BH_GRANT);
        o.mask     = (s == BH_GRANT);
        o.stall    = (s != BH_RUN);
        return o;
    endfunction

endpackage

// File: rtl/brq_next.sv
module brq_next
    import brq_pkg::*;
(
    input  bh_state_e cur,
    input  logic      req,
    input  logic      last,
    output bh_state_e nxt
);
    always_comb nxt = bh_next(cur, req, last);
endmodule

// File: rtl/brq_state_reg.sv
module brq_state_reg
    import brq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bh_state_e nxt,
    output bh_state_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= BH_RUN;
        else     cur <= nxt;
    end

    // the wait state never lasts more than one clock
    p_arm_one_clock_r8: assert property (@(posedge clk) disable iff (rst)
        (cur == BH_ARM) |=> (cur == BH_GRANT));
endmodule

// File: rtl/brq_out_decode.sv
module brq_out_decode
    import brq_pkg::*;
(
    input  bh_state_e cur,
    output bh_out_s   outs
);
    always_comb outs = bh_decode(cur);
endmodule

// File: rtl/brq_ctrl.sv
module brq_ctrl
    import brq_pkg::*;
#(
    parameter int MAX_TSTATES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic busrq_n,
    input  logic last_t,
    output logic stall,
    output logic busak_n,
    output logic bus_float,
    output logic irq_mask
);
    localparam int LAT_LIMIT = MAX_TSTATES + 2;
    localparam int LAT_W     = $clog2(LAT_LIMIT + 2) + 1;

    bh_state_e cur_st;
    bh_state_e nxt_st;
    bh_out_s   outs;
    logic      req;

    assign req = ~busrq_n;

    brq_next u_next (
        .cur  (cur_st),
        .req  (req),
        .last (last_t),
        .nxt  (nxt_st)
    );

    brq_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_st),
        .cur (cur_st)
    );

    brq_out_decode u_dec (
        .cur  (cur_st),
        .outs (outs)
    );

    assign stall     = outs.stall;
    assign busak_n   = ~outs.ack;
    assign bus_float = outs.float_en;
    assign irq_mask  = outs.mask;

    // latency watch: cycles a request has waited without being granted
    logic [LAT_W-1:0] wait_cnt;
    always_ff @(posedge clk) begin
        if (rst || busrq_n || !busak_n) wait_cnt <= '0;
        else if (wait_cnt != {LAT_W{1'b1}}) wait_cnt <= wait_cnt + 1'b1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!stall && busak_n && !bus_float && !irq_mask));

    p_no_sample_r2: assert property (@(posedge clk) disable iff (rst)
        (!stall && !last_t) |=> !stall);

    p_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (!stall && last_t && !busrq_n) |=> (stall && busak_n && !bus_float));

    p_float_next_r3: assert property (@(posedge clk) disable iff (rst)
        (stall && busak_n) |=> (!busak_n && bus_float && irq_mask));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!busak_n && !busrq_n) |=> !busak_n);

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (!busak_n && busrq_n) |=> (busak_n && !bus_float && !stall && !irq_mask));

    p_stall_span_r10: assert property (@(posedge clk) disable iff (rst)
        (!busak_n && !busrq_n) |=> stall);

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= LAT_W'(LAT_LIMIT));
endmodule

// File: tb/brq_ctrl_tb.sv
module brq_ctrl_tb;
    localparam int MAX_T = 6;

    logic clk = 1'b0;
    logic rst;
    logic busrq_n;
    logic last_t;
    logic stall, busak_n, bus_float, irq_mask;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    brq_ctrl #(.MAX_TSTATES(MAX_T)) u_dut (
        .clk(clk), .rst(rst), .busrq_n(busrq_n), .last_t(last_t),
        .stall(stall), .busak_n(busak_n), .bus_float(bus_float), .irq_mask(irq_mask)
    );

    // reference: 0 running, 1 wait state, 2 granted
    int m_st = 0;

    function automatic int ref_next(int s, logic rq_n, logic lt);
        if (s == 0) return (!rq_n && lt) ? 1 : 0;
        if (s == 1) return 2;
        return rq_n ? 0 : 2;
    endfunction

    always @(posedge clk) begin
        if (rst) m_st <= 0;
        else     m_st <= ref_next(m_st, busrq_n, last_t);
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "stall (R10)",   stall,     m_st != 0);
        chk(tag, "busak_n",       busak_n,   m_st != 2);
        chk(tag, "bus_float",     bus_float, m_st == 2);
        chk(tag, "irq_mask (R7)", irq_mask,  m_st == 2);
        chk("R4", "ack/float pairing", busak_n, ~bus_float);
    endtask

    // drive at negedge, take the edge, check at the next negedge
    task automatic step(logic rq_n, logic lt, string tag);
        busrq_n = rq_n;
        last_t  = lt;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seq_cnt, seq_len, lat, rq_hold;
        void'($urandom(32'h5eed_0b42));
        rst = 1'b1; busrq_n = 1'b1; last_t = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R1", "stall",     stall,     1'b0);
        chk("R1", "busak_n",   busak_n,   1'b1);
        chk("R1", "bus_float", bus_float, 1'b0);
        chk("R1", "irq_mask",  irq_mask,  1'b0);
        rst = 1'b0;

        // R2: request ignored mid-cycle
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R2");
        chk("R2", "stall stays low", stall, 1'b0);
        // R3: accept at last state, wait state, then float
        step(1'b0, 1'b1, "R3");
        chk("R3", "wait-state stall", stall, 1'b1);
        chk("R3", "no float yet", bus_float, 1'b0);
        step(1'b0, 1'b0, "R3");
        chk("R3", "floated", bus_float, 1'b1);
        chk("R3", "acknowledged", busak_n, 1'b0);
        chk("R7", "mask during grant", irq_mask, 1'b1);
        // R5: long hold, last_t toggling
        for (int i = 0; i < 25; i++) step(1'b0, 1'(i % 2), "R5");
        chk("R5", "still granted", busak_n, 1'b0);
        // R6: release
        step(1'b1, 1'b0, "R6");
        chk("R6", "ack dropped", busak_n, 1'b1);
        chk("R6", "drivers back", bus_float, 1'b0);
        chk("R6", "stall released", stall, 1'b0);
        chk("R7", "mask cleared", irq_mask, 1'b0);
        // R8: withdrawal during wait state
        step(1'b0, 1'b1, "R8");
        step(1'b1, 1'b0, "R8");
        chk("R8", "grant despite withdrawal", bus_float, 1'b1);
        step(1'b1, 1'b0, "R8");
        chk("R8", "released after one grant clock", bus_float, 1'b0);

        // random phase with sequencer model; R9 latency measured here
        seq_cnt = 0; seq_len = 3; lat = 0; rq_hold = 0;
        busrq_n = 1'b1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            logic lt;
            logic rq;
            if (rq_hold == 0) begin
                rq = busrq_n;
                if ($urandom_range(0, 9) < 3) rq = ~busrq_n;
                rq_hold = $urandom_range(1, 12);
            end else begin
                rq = busrq_n;
                rq_hold--;
            end
            lt = 1'b0;
            if (!stall) begin
                seq_cnt++;
                if (seq_cnt >= seq_len) begin
                    lt = 1'b1;
                    seq_cnt = 0;
                    seq_len = $urandom_range(3, MAX_T);
                end
            end
            step(rq, lt, "R9");
            if (!busrq_n && busak_n) lat++;
            else lat = 0;
            if (lat > MAX_T + 2) begin
                chk("R9", "grant latency bound", 1'b1, 1'b0);
                lat = 0;
            end
        end
        finish_run();
    end
endmodule